// File: doc/BRIEF.md
# Start/Stop/Step Hexadecimal Digit Counter

This block drives one seven-segment digit with a 4-bit count from 0 to F. Four push-buttons control it: start, stop, step and clear. After start is pressed, the count advances once per one-second tick until stop is pressed. A step press adds one to the count whether or not the block is running. A clear press zeroes the count and stops the block.

The whole block runs on the system clock. The one-second rate arrives as `tick_i`, a single-cycle enable pulse, and no divided clock is used. Each button passes through a two-flop synchroniser and then a rising-edge detector, so one press causes exactly one action. The segment and anode outputs are active-low and connect directly to a single digit.

Top module: `hex_step_counter`

## Requirements
- R1: Each button passes through a two-flop synchroniser and acts only on its rising edge. A press held for any number of cycles causes exactly one action. That action shows at the outputs just after the third rising clock edge that samples the button high.
- R2: While running, each cycle with `tick_i` high advances the count by one at the next clock edge. While stopped, `tick_i` has no effect on the count.
- R3: A start press puts the block into the running state, and `running_o` goes high.
- R4: A stop press leaves the running state and freezes the count. If stop and start act in the same cycle, stop wins.
- R5: A step press adds exactly one to the count in both the running and the stopped state. If a step action and a tick arrive in the same cycle while running, the count advances by one only.
- R6: A clear press sets the count to 0 and the block to stopped. Clear takes priority over stop, start and step.
- R7: The count wraps from F to 0, whether it gets there by a tick or by a step.
- R8: `term_o` is high exactly when the count is F.
- R9: `seg_no[0]` is segment a and `seg_no[6]` is segment g, and all segments are active-low. Digit 0 gives 7'h40, 8 gives 7'h00, A gives 7'h08 and F gives 7'h0E. The remaining values use the usual hex glyphs (b and d in lower case).
- R10: `an_no` is held at 0 at all times, which enables the single digit.
- R11: After reset, the count is 0 and the block is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse at the counting rate |
| btn_start_i | input | 1 | Start button, raw input |
| btn_stop_i | input | 1 | Stop button, raw input |
| btn_step_i | input | 1 | Step button, raw input |
| btn_clear_i | input | 1 | Clear button, raw input |
| count_o | output | 4 | Current count |
| running_o | output | 1 | High while in the running state |
| term_o | output | 1 | High when the count is F |
| seg_no | output | 7 | Segments a..g, active-low |
| an_no | output | 1 | Digit anode enable, active-low |

## Verification
The assertions check the cycle-level rules on every cycle:
- an edge pulse never lasts two cycles;
- clear zeroes the count and stops the block;
- stop beats start;
- an enabled advance adds exactly one, with the wrap included;
- the count holds when nothing enables it.

Only the bench scenarios can show the end-to-end behaviour:
- the three-edge latency from a raw button to an action;
- a long hold giving a single step;
- a step and a tick in the same cycle giving one increment;
- the exact segment patterns for the digits.

// File: rtl/hsc_pkg.sv
package hsc_pkg;
  localparam int CNT_W       = 4;
  localparam int SEG_W       = 7;
  localparam int NUM_BTN     = 4;
  localparam int SYNC_STAGES = 2;
  // button slot positions in the conditioned vector
  localparam int B_START = 0;
  localparam int B_STOP  = 1;
  localparam int B_STEP  = 2;
  localparam int B_CLEAR = 3;
endpackage

// File: rtl/btn_edge.sv
module btn_edge #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  output logic [N-1:0] pulse_o
);
  logic [N-1:0] stg_q [STAGES];
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= raw_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign pulse_o = stg_q[STAGES-1] & ~prev_q;

  for (genvar b = 0; b < N; b++) begin : g_chk
    a_r1_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pulse_o[b] |=> !pulse_o[b]);
  end
endmodule

// File: rtl/run_ctrl.sv
module run_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic stop_i,
  input  logic clear_i,
  output logic run_o
);
  logic run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_q <= 1'b0;
    else if (clear_i) run_q <= 1'b0;
    else if (stop_i)  run_q <= 1'b0;
    else if (start_i) run_q <= 1'b1;
  end

  assign run_o = run_q;

  a_r3_start_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !clear_i) |=> run_o);
  a_r4_stop_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !run_o);
  a_r6_clear_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !run_o);
endmodule

// File: rtl/step_counter.sv
module step_counter #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic         run_i,
  input  logic         tick_i,
  output logic [W-1:0] count_o,
  output logic         term_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic         adv;

  // step and tick together still give a single increment
  assign adv = step_i | (run_i & tick_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (adv)     cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
  assign term_o  = (cnt_q == MAX);

  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0));
  a_r5_plus_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && (step_i || (run_i && tick_i))) |=> (count_o == W'($past(count_o) + 1'b1)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !step_i && !(run_i && tick_i)) |=> $stable(count_o));
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder #(
  parameter int W     = 4,
  parameter int SEG_W = 7
) (
  input  logic [W-1:0]     val_i,
  output logic [SEG_W-1:0] seg_no
);
  logic [SEG_W-1:0] lit; // bit0 = a .. bit6 = g, active-high

  always_comb begin
    unique case (val_i[3:0])
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end

  assign seg_no = ~lit;
endmodule

// File: rtl/hex_step_counter.sv
module hex_step_counter
  import hsc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             btn_start_i,
  input  logic             btn_stop_i,
  input  logic             btn_step_i,
  input  logic             btn_clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             running_o,
  output logic             term_o,
  output logic [SEG_W-1:0] seg_no,
  output logic             an_no
);
  logic [NUM_BTN-1:0] raw, pulse;

  always_comb begin
    raw          = '0;
    raw[B_START] = btn_start_i;
    raw[B_STOP]  = btn_stop_i;
    raw[B_STEP]  = btn_step_i;
    raw[B_CLEAR] = btn_clear_i;
  end

  btn_edge #(.N(NUM_BTN), .STAGES(SYNC_STAGES)) i_btn_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw),
    .pulse_o(pulse)
  );

  run_ctrl i_run_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(pulse[B_START]),
    .stop_i (pulse[B_STOP]),
    .clear_i(pulse[B_CLEAR]),
    .run_o  (running_o)
  );

  step_counter #(.W(CNT_W)) i_step_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clear_i(pulse[B_CLEAR]),
    .step_i (pulse[B_STEP]),
    .run_i  (running_o),
    .tick_i (tick_i),
    .count_o(count_o),
    .term_o (term_o)
  );

  seg_encoder #(.W(CNT_W), .SEG_W(SEG_W)) i_seg_encoder (
    .val_i (count_o),
    .seg_no(seg_no)
  );

  assign an_no = 1'b0; // R10: single digit always enabled

  a_r8_term_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !pulse[B_STEP] && !pulse[B_CLEAR] && !(running_o && tick_i)) |=> term_o);
  a_r7_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term_o && !pulse[B_CLEAR] && (pulse[B_STEP] || (running_o && tick_i))) |=> (count_o == '0));
endmodule

// File: tb/test_hex_step_counter.sv
`timescale 1ns/1ps
module test_hex_step_counter;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [3:0] btn = '0; // {clear, step, stop, start}
  logic [3:0] count;
  logic running, term, an;
  logic [6:0] seg;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  hex_step_counter i_hex_step_counter (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .btn_start_i(btn[0]), .btn_stop_i(btn[1]), .btn_step_i(btn[2]), .btn_clear_i(btn[3]),
    .count_o(count), .running_o(running), .term_o(term), .seg_no(seg), .an_no(an)
  );

  localparam logic [3:0] M_START = 4'b0001, M_STOP = 4'b0010, M_STEP = 4'b0100, M_CLEAR = 4'b1000;

  typedef struct packed {
    logic [2:0] op;   // 0 tick, 1 start, 2 stop, 3 step, 4 clear
    logic [3:0] cnt;
    logic       run;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 4'h0, 1'b1}, '{3'd0, 4'h1, 1'b1}, '{3'd0, 4'h2, 1'b1},
    '{3'd2, 4'h2, 1'b0}, '{3'd0, 4'h2, 1'b0}, '{3'd3, 4'h3, 1'b0},
    '{3'd1, 4'h3, 1'b1}, '{3'd3, 4'h4, 1'b1}, '{3'd4, 4'h0, 1'b0},
    '{3'd0, 4'h0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic press(input logic [3:0] m);
    @(negedge clk); btn = m;
    repeat (3) @(posedge clk);
    @(negedge clk); btn = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic do_op(input logic [2:0] op);
    case (op)
      3'd0: pulse_tick();
      3'd1: press(M_START);
      3'd2: press(M_STOP);
      3'd3: press(M_STEP);
      default: press(M_CLEAR);
    endcase
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 count", count, 0);
    check("R11 running", running, 0);
    check("R8 term at 0", term, 0);
    check("R9 glyph 0", seg, 7'h40);
    check("R10 anode", an, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // table walk: R2 R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].op);
      check("R2/R3/R4/R5/R6 table count", count, VECS[i].cnt);
      check("R2/R3/R4/R5/R6 table running", running, VECS[i].run);
    end

    // R1 latency: action after third sampling edge
    @(negedge clk); btn = M_STEP;
    repeat (2) @(posedge clk);
    @(negedge clk); check("R1 no action before third edge", count, 0);
    @(negedge clk); check("R1 action on third edge", count, 1);
    // R1 long hold gives one step
    repeat (10) @(negedge clk);
    check("R1 held press single action", count, 1);
    btn = '0; repeat (3) @(negedge clk);

    // R5 step + tick same cycle while running
    press(M_START);
    @(negedge clk); btn = M_STEP;
    repeat (2) @(posedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R5 step+tick one increment", count, 2);
    btn = '0; repeat (3) @(negedge clk);

    // R4 stop beats start
    press(M_START | M_STOP);
    check("R4 stop beats start", running, 0);

    // R9 glyph 8 and A
    for (int k = 0; k < 6; k++) press(M_STEP);
    check("R9 glyph 8", seg, 7'h00);
    press(M_STEP); press(M_STEP);
    check("R9 glyph A", seg, 7'h08);

    // R7 R8 wrap by step
    for (int k = 0; k < 5; k++) press(M_STEP);
    check("R8 term at F", term, 1);
    check("R9 glyph F", seg, 7'h0E);
    press(M_STEP);
    check("R7 wrap by step", count, 0);
    check("R8 term cleared", term, 0);

    // R7 wrap by tick
    press(M_START);
    for (int k = 0; k < 15; k++) pulse_tick();
    check("R2 ticks reach F", count, 4'hF);
    pulse_tick();
    check("R7 wrap by tick", count, 0);

    // R6 clear beats start/step
    pulse_tick(); pulse_tick();
    press(M_CLEAR | M_START | M_STEP);
    check("R6 clear count", count, 0);
    check("R6 clear stops", running, 0);
    check("R10 anode", an, 0);

    finish_run();
  end
endmodule